// File: doc/BRIEF.md
# Four-Thread Interrupt Presentation Context

This block holds the interrupt presentation state of several hardware threads (four by default). Each thread has a notification status byte, a current processor priority, a pending-priority bitmap for its pool context and a backlog hint byte. A delivery port accepts one interrupt per cycle. The interrupt carries a priority from 0 to 7, where a smaller number means more urgent. It also carries a kind: direct to one thread, aimed at one thread's pool context, or offered to the whole thread group. A thread raises its exception line while its status byte is nonzero.

A group interrupt goes to the lowest-numbered thread that is idle and whose current priority the interrupt beats. When no thread qualifies, the interrupt is parked in a single backlog slot and its priority is posted in every thread's backlog hint. A later priority write that relaxes a thread far enough hands the parked interrupt to that thread. Software takes an interrupt through the acknowledge port. The acknowledge returns the status byte together with the interrupt priority, and then raises the thread's current priority to that level.

Top module: `ipc_present_top`

## Requirements
- R1: After reset every thread reads status 0x00, current priority 0xFF, pool bitmap 0x00 and backlog hint 0xFF, and every exception line is low.
- R2: `phys_word` for the thread chosen by `rd_thr` packs {status[31:24], current priority[23:16], 0x00[15:8], backlog hint[7:0]}. `pool_word` packs {0x00, 0x00, pool bitmap[15:8], 0x00}.
- R3: A direct delivery (kind 0) to thread T with priority P sets T's status to 0x80 one cycle later when P < T's current priority. The condition also requires that T is idle or that P beats T's held priority. Otherwise T's state is unchanged. Kind 3 is ignored.
- R4: A pool delivery (kind 1) always sets bit (0x80 >> P) in T's pool bitmap. Under the same beat condition as R3 it also sets T's status to 0x40.
- R5: While `ack_req` is high, `ack_word` shows {status, held priority} for a busy thread, or {0x00, current priority} for an idle one. At the next edge a busy thread loads its current priority with the held priority and clears its status. After a pool presentation it also clears the pool bitmap bit of that priority.
- R6: A group delivery (kind 2) sets status 0x82 on exactly one thread: the lowest-numbered thread that is idle and whose current priority is above P.
- R7: A group delivery with no eligible thread changes no status and sets every backlog hint to the parked priority. When a backlog already exists, the parked priority is the more urgent of the old and new priorities.
- R8: A priority write of V to thread T takes the parked interrupt when the parked priority is below V and T keeps no pending interrupt. T then shows status 0x82 with current priority V, and every backlog hint returns to 0xFF.
- R9: A priority write stores V as is. A pending interrupt on that thread stays only if its held priority is still below V. Otherwise the status clears.
- R10: `exc_out[T]` is high exactly when thread T's status byte is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | Interrupt delivery strobe |
| dlv_kind | input | 2 | 0 direct, 1 pool, 2 group, 3 ignored |
| dlv_thr | input | TW | Target thread for direct and pool kinds |
| dlv_prio | input | 3 | Interrupt priority, 0 most urgent |
| cppr_wr | input | 1 | Current-priority write strobe |
| cppr_thr | input | TW | Thread written |
| cppr_val | input | 8 | Priority value written |
| ack_req | input | 1 | Acknowledge strobe |
| ack_thr | input | TW | Thread acknowledged |
| ack_word | output | 16 | {status, priority} returned by acknowledge |
| rd_thr | input | TW | Thread selected for status reads |
| phys_word | output | 32 | Physical status word of the selected thread |
| pool_word | output | 32 | Pool word of the selected thread |
| exc_out | output | NTHR | Per-thread exception request |

## Verification
A wrong status byte shows on `exc_out` in the cycle after the faulty update. It also shows on the next read or acknowledge of that thread, because the acknowledge returns the held priority and commits it to the current priority. A wrong group pick or a wrong backlog decision reaches the ports in two ways. The wrong thread raises its exception, or a backlog hint byte differs on every thread at once. Stale backlog state may stay hidden until a later priority write lets it drain, so the random stream mixes writes of all values with group deliveries and compares every thread's words after each operation.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  typedef enum logic [1:0] {
    DLV_DIRECT = 2'd0,
    DLV_POOL   = 2'd1,
    DLV_GROUP  = 2'd2,
    DLV_NONE   = 2'd3
  } dlv_kind_e;

  localparam logic [7:0] NSR_IDLE   = 8'h00;
  localparam logic [7:0] NSR_DIRECT = 8'h80;
  localparam logic [7:0] NSR_POOL   = 8'h40;
  localparam logic [7:0] NSR_GROUP  = 8'h82;
  localparam logic [7:0] PRIO_OPEN  = 8'hFF;

  // true when priority p is more urgent than level c
  function automatic logic prio_beats(input logic [2:0] p, input logic [7:0] c);
    return {5'b00000, p} < c;
  endfunction

  function automatic logic [7:0] prio_bit(input logic [2:0] p);
    return 8'h80 >> p;
  endfunction

  function automatic logic [2:0] prio_min(input logic [2:0] a, input logic [2:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] pack_phys(input logic [7:0] nsr, input logic [7:0] cppr,
                                            input logic [7:0] lsmfb);
    return {nsr, cppr, 8'h00, lsmfb};
  endfunction

endpackage

// File: rtl/ipc_thread_ctx.sv
module ipc_thread_ctx
  import ipc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dlv_hit,
  input  logic       dlv_pool,
  input  logic [7:0] dlv_code,
  input  logic [2:0] dlv_prio,
  input  logic       cppr_we,
  input  logic [7:0] cppr_val,
  input  logic       bl_take,
  input  logic [2:0] bl_prio,
  input  logic       hint_set,
  input  logic       hint_clr,
  input  logic [2:0] hint_val,
  input  logic       ack_we,
  output logic [7:0] nsr,
  output logic [7:0] cppr,
  output logic [7:0] ipb,
  output logic [7:0] lsmfb,
  output logic [2:0] pend
);

  logic busy;
  logic dlv_present;
  logic keep_on_wr;

  assign busy        = (nsr != NSR_IDLE);
  assign dlv_present = prio_beats(dlv_prio, cppr) && (!busy || (dlv_prio < pend));
  assign keep_on_wr  = busy && prio_beats(pend, cppr_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsr  <= NSR_IDLE;
      cppr <= PRIO_OPEN;
      ipb  <= 8'h00;
      pend <= 3'd7;
    end else if (ack_we) begin
      if (busy) begin
        cppr <= {5'b00000, pend};
        nsr  <= NSR_IDLE;
        if (nsr == NSR_POOL) ipb <= ipb & ~prio_bit(pend);
      end
    end else if (cppr_we) begin
      cppr <= cppr_val;
      if (bl_take) begin
        nsr  <= NSR_GROUP;
        pend <= bl_prio;
      end else if (!keep_on_wr) begin
        nsr <= NSR_IDLE;
      end
    end else if (dlv_hit) begin
      if (dlv_pool) ipb <= ipb | prio_bit(dlv_prio);
      if (dlv_present) begin
        nsr  <= dlv_code;
        pend <= dlv_prio;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lsmfb <= PRIO_OPEN;
    else if (hint_clr) lsmfb <= PRIO_OPEN;
    else if (hint_set) lsmfb <= {5'b00000, hint_val};
  end

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && busy) |=> (nsr == NSR_IDLE && cppr == {5'b00000, $past(pend)}));

  // R9
  cppr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_we && !ack_we) |=> (cppr == $past(cppr_val)));

  // R3
  present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_hit && dlv_present && !ack_we && !cppr_we) |=> (nsr == $past(dlv_code)));

endmodule

// File: rtl/ipc_group_arb.sv
module ipc_group_arb
  import ipc_pkg::*;
#(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grp_req,
  input  logic [2:0]           grp_prio,
  input  logic [NTHR-1:0][7:0] cppr_v,
  input  logic [NTHR-1:0]      idle_mask,
  input  logic                 cppr_wr,
  input  logic [TW-1:0]        cppr_thr,
  input  logic [7:0]           cppr_val,
  input  logic                 wr_keep,
  output logic [NTHR-1:0]      pick,
  output logic                 bl_set,
  output logic [NTHR-1:0]      bl_take_v,
  output logic [2:0]           bl_prio,
  output logic [2:0]           hint_val,
  output logic                 bl_valid
);

  logic [NTHR-1:0] elig;
  logic            take_ok;

  always_comb begin
    for (int t = 0; t < NTHR; t++)
      elig[t] = idle_mask[t] && prio_beats(grp_prio, cppr_v[t]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (grp_req && elig[t] && !found) begin
        pick[t] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign bl_set   = grp_req && (elig == '0);
  assign hint_val = bl_valid ? prio_min(bl_prio, grp_prio) : grp_prio;
  assign take_ok  = cppr_wr && bl_valid && prio_beats(bl_prio, cppr_val) && !wr_keep;

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_take
      assign bl_take_v[t] = take_ok && (cppr_thr == TW'(t));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_valid <= 1'b0;
      bl_prio  <= 3'd7;
    end else if (take_ok) begin
      bl_valid <= 1'b0;
    end else if (bl_set) begin
      bl_valid <= 1'b1;
      bl_prio  <= hint_val;
    end
  end

  // R6
  one_pick_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pick));

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_set && !cppr_wr) |=> bl_valid);

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> !bl_valid);

endmodule

// File: rtl/ipc_present_top.sv
module ipc_present_top
  import ipc_pkg::*;
#(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dlv_valid,
  input  logic [1:0]      dlv_kind,
  input  logic [TW-1:0]   dlv_thr,
  input  logic [2:0]      dlv_prio,
  input  logic            cppr_wr,
  input  logic [TW-1:0]   cppr_thr,
  input  logic [7:0]      cppr_val,
  input  logic            ack_req,
  input  logic [TW-1:0]   ack_thr,
  output logic [15:0]     ack_word,
  input  logic [TW-1:0]   rd_thr,
  output logic [31:0]     phys_word,
  output logic [31:0]     pool_word,
  output logic [NTHR-1:0] exc_out
);

  logic [NTHR-1:0][7:0] nsr_v, cppr_v, ipb_v, lsmfb_v;
  logic [NTHR-1:0][2:0] pend_v;
  logic [NTHR-1:0]      idle_mask, pick, bl_take_v, dlv_hit, ack_hit, wr_hit;
  logic                 grp_req, bl_set, bl_valid, wr_keep;
  logic [2:0]           bl_prio, hint_val;
  logic [7:0]           dlv_code;
  logic                 is_single;

  assign grp_req   = dlv_valid && (dlv_kind == DLV_GROUP);
  assign is_single = dlv_valid && (dlv_kind == DLV_DIRECT || dlv_kind == DLV_POOL);
  assign dlv_code  = (dlv_kind == DLV_POOL) ? NSR_POOL :
                     (dlv_kind == DLV_GROUP) ? NSR_GROUP : NSR_DIRECT;
  assign wr_keep   = (nsr_v[cppr_thr] != NSR_IDLE) && prio_beats(pend_v[cppr_thr], cppr_val);

  ipc_group_arb #(.NTHR(NTHR)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_req   (grp_req),
    .grp_prio  (dlv_prio),
    .cppr_v    (cppr_v),
    .idle_mask (idle_mask),
    .cppr_wr   (cppr_wr),
    .cppr_thr  (cppr_thr),
    .cppr_val  (cppr_val),
    .wr_keep   (wr_keep),
    .pick      (pick),
    .bl_set    (bl_set),
    .bl_take_v (bl_take_v),
    .bl_prio   (bl_prio),
    .hint_val  (hint_val),
    .bl_valid  (bl_valid)
  );

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
      assign idle_mask[t] = (nsr_v[t] == NSR_IDLE);
      assign dlv_hit[t]   = (is_single && dlv_thr == TW'(t)) || pick[t];
      assign ack_hit[t]   = ack_req && ack_thr == TW'(t);
      assign wr_hit[t]    = cppr_wr && cppr_thr == TW'(t);
      assign exc_out[t]   = (nsr_v[t] != NSR_IDLE);

      ipc_thread_ctx ctx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dlv_hit  (dlv_hit[t]),
        .dlv_pool (dlv_kind == DLV_POOL),
        .dlv_code (dlv_code),
        .dlv_prio (dlv_prio),
        .cppr_we  (wr_hit[t]),
        .cppr_val (cppr_val),
        .bl_take  (bl_take_v[t]),
        .bl_prio  (bl_prio),
        .hint_set (bl_set),
        .hint_clr (|bl_take_v),
        .hint_val (hint_val),
        .ack_we   (ack_hit[t]),
        .nsr      (nsr_v[t]),
        .cppr     (cppr_v[t]),
        .ipb      (ipb_v[t]),
        .lsmfb    (lsmfb_v[t]),
        .pend     (pend_v[t])
      );

      // R3
      direct_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_kind == DLV_DIRECT && dlv_thr == TW'(t) && idle_mask[t] &&
         prio_beats(dlv_prio, cppr_v[t]) && !ack_hit[t] && !wr_hit[t]) |=> exc_out[t]);

      // R8
      take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bl_take_v[t] && !ack_hit[t]) |=> (nsr_v[t] == NSR_GROUP && lsmfb_v[t] == PRIO_OPEN));

      // R10
      exc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_out[t]) |-> (nsr_v[t] == NSR_DIRECT || nsr_v[t] == NSR_POOL ||
                               nsr_v[t] == NSR_GROUP));
    end
  endgenerate

  assign ack_word  = (nsr_v[ack_thr] != NSR_IDLE) ? {nsr_v[ack_thr], 5'b00000, pend_v[ack_thr]}
                                                   : {NSR_IDLE, cppr_v[ack_thr]};
  assign phys_word = pack_phys(nsr_v[rd_thr], cppr_v[rd_thr], lsmfb_v[rd_thr]);
  assign pool_word = {16'h0000, ipb_v[rd_thr], 8'h00};

endmodule

// File: tb/ipc_present_top_tb.sv
`timescale 1ns/1ps
module ipc_present_top_tb_top;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dlv_valid = 1'b0, cppr_wr = 1'b0, ack_req = 1'b0;
  logic [1:0] dlv_kind = 2'd0;
  logic [1:0] dlv_thr = 2'd0, cppr_thr = 2'd0, ack_thr = 2'd0, rd_thr = 2'd0;
  logic [2:0] dlv_prio = 3'd0;
  logic [7:0] cppr_val = 8'h00;
  logic [15:0] ack_word;
  logic [31:0] phys_word, pool_word;
  logic [N-1:0] exc_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_nsr[N], m_cppr[N], m_ipb[N], m_lsm[N];
  logic [2:0] m_pend[N];
  logic m_blv;
  logic [2:0] m_blp;

  always #2.5 clk = ~clk;

  ipc_present_top #(.NTHR(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_kind(dlv_kind),
    .dlv_thr(dlv_thr), .dlv_prio(dlv_prio), .cppr_wr(cppr_wr), .cppr_thr(cppr_thr),
    .cppr_val(cppr_val), .ack_req(ack_req), .ack_thr(ack_thr), .ack_word(ack_word),
    .rd_thr(rd_thr), .phys_word(phys_word), .pool_word(pool_word), .exc_out(exc_out)
  );

  function automatic logic [7:0] bitof(input logic [2:0] p);
    return 8'h80 >> p;
  endfunction

  function automatic logic wins(input logic [2:0] p, input logic [7:0] lvl);
    return {5'd0, p} < lvl;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int t = 0; t < N; t++) begin
      rd_thr = t[1:0];
      #0.1;
      check({req, " R2 phys"}, phys_word, {m_nsr[t], m_cppr[t], 8'h00, m_lsm[t]});
      check({req, " R4 pool"}, pool_word, {16'h0, m_ipb[t], 8'h00});
      check({req, " R10 exc"}, {31'd0, exc_out[t]}, {31'd0, m_nsr[t] != 8'h00});
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < N; t++) begin
      m_nsr[t] = 8'h00; m_cppr[t] = 8'hFF; m_ipb[t] = 8'h00; m_lsm[t] = 8'hFF; m_pend[t] = 3'd7;
    end
    m_blv = 1'b0; m_blp = 3'd7;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    dlv_valid = 1'b0; cppr_wr = 1'b0; ack_req = 1'b0;
  endtask

  task automatic do_dlv(input logic [1:0] k, input int t, input logic [2:0] p);
    dlv_valid = 1'b1; dlv_kind = k; dlv_thr = t[1:0]; dlv_prio = p;
    step();
    if (k == 2'd0 || k == 2'd1) begin
      if (k == 2'd1) m_ipb[t] |= bitof(p);
      if (wins(p, m_cppr[t]) && (m_nsr[t] == 8'h00 || p < m_pend[t])) begin
        m_nsr[t] = (k == 2'd1) ? 8'h40 : 8'h80; m_pend[t] = p;
      end
    end else if (k == 2'd2) begin
      int sel = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m_nsr[i] == 8'h00 && wins(p, m_cppr[i])) sel = i;
      if (sel >= 0) begin
        m_nsr[sel] = 8'h82; m_pend[sel] = p;
      end else begin
        m_blp = (m_blv && m_blp < p) ? m_blp : p;
        m_blv = 1'b1;
        for (int i = 0; i < N; i++) m_lsm[i] = {5'd0, m_blp};
      end
    end
  endtask

  task automatic do_cppr(input int t, input logic [7:0] v);
    logic keep;
    cppr_wr = 1'b1; cppr_thr = t[1:0]; cppr_val = v;
    step();
    keep = (m_nsr[t] != 8'h00) && wins(m_pend[t], v);
    m_cppr[t] = v;
    if (m_blv && wins(m_blp, v) && !keep) begin
      m_nsr[t] = 8'h82; m_pend[t] = m_blp; m_blv = 1'b0;
      for (int i = 0; i < N; i++) m_lsm[i] = 8'hFF;
    end else if (!keep) begin
      m_nsr[t] = 8'h00;
    end
  endtask

  task automatic do_ack(input int t);
    logic [15:0] exp;
    ack_req = 1'b1; ack_thr = t[1:0];
    #0.1;
    exp = (m_nsr[t] != 8'h00) ? {m_nsr[t], 5'd0, m_pend[t]} : {8'h00, m_cppr[t]};
    check("R5 ack word", {16'd0, ack_word}, {16'd0, exp});
    step();
    if (m_nsr[t] != 8'h00) begin
      m_cppr[t] = {5'd0, m_pend[t]};
      if (m_nsr[t] == 8'h40) m_ipb[t] &= ~bitof(m_pend[t]);
      m_nsr[t] = 8'h00;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R3 direct presentation, then R5 ack and R9 reopen
    do_dlv(2'd0, 1, 3'd5);  check_all("R3 direct");
    check("R3 exc", {28'd0, exc_out}, 32'h2);
    do_ack(1);              check_all("R5 after ack");
    check("R5 cppr", {24'd0, m_cppr[1]}, 32'h5);
    do_cppr(1, 8'hFF);      check_all("R9 reopen");
    // R3 not beating
    do_cppr(2, 8'h03);
    do_dlv(2'd0, 2, 3'd3);  check_all("R3 blocked");
    do_dlv(2'd3, 0, 3'd1);  check_all("R3 kind3 ignored");
    do_cppr(2, 8'hFF);
    // R4 pool
    do_dlv(2'd1, 1, 3'd5);  check_all("R4 pool");
    rd_thr = 2'd1; #0.1;
    check("R4 ipb bit", pool_word, 32'h0000_0400);
    do_ack(1);              check_all("R4 R5 pool ack");
    do_cppr(1, 8'hFF);
    // R6 group
    do_dlv(2'd2, 0, 3'd6);  check_all("R6 group");
    check("R6 pick", {28'd0, exc_out}, 32'h1);
    do_ack(0); do_cppr(0, 8'hFF);
    // R7 backlog then R8 drain
    for (int t = 0; t < N; t++) do_cppr(t, 8'h02);
    do_dlv(2'd2, 0, 3'd3);  check_all("R7 backlog");
    check("R7 no exc", {28'd0, exc_out}, 32'h0);
    do_cppr(3, 8'h04);      check_all("R8 take");
    rd_thr = 2'd3; #0.1;
    check("R8 word", phys_word, 32'h8204_00FF);
    do_ack(3);              check_all("R8 ack");
    do_cppr(3, 8'hFF);      check_all("R8 reopen");
    for (int t = 0; t < 3; t++) do_cppr(t, 8'hFF);
    // R9 pending dropped when no longer beating
    do_dlv(2'd0, 0, 3'd4);
    do_cppr(0, 8'h04);      check_all("R9 drop");
    do_cppr(0, 8'hFF);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int t = $urandom_range(0, N - 1);
      logic [2:0] p = 3'($urandom_range(0, 7));
      if (op < 4)      do_dlv(2'($urandom_range(0, 2)), t, p);
      else if (op < 7) do_cppr(t, ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 8)));
      else             do_ack(t);
      check_all("R3-mix R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule